// File: doc/BRIEF.md
# Register-Routed Stream Crossbar

This block joins a set of AXI4-Stream inputs to a set of AXI4-Stream outputs. Each output has a route register that names one input as its source or switches the output off. Software writes these registers through a simple write/read register port. A write only stages the value. A separate commit write copies every staged value into a pending route for each output. Each output adopts its pending route only between packets, so no packet is split across two sources.

Each output takes its route from exactly one input. One input may feed several outputs at the same time. In that case the input only advances when every output that selects it is ready. Each of those outputs shows a valid beat only while the other outputs sharing the source are ready. As a result, every output that selects an input sees the same set of accepted beats. To stop all traffic, software switches every output off and then commits.

Top module: `stream_xbar`

## Requirements
- R1: After reset every output is off, so `m_valid` stays low whatever the inputs do and `s_ready` is low. Every route register reads back 0x8000_0000.
- R2: The route register of output i is at byte address 0x40 + 4*i. Bits [3:0] name the source input and bit 31 switches the output off. A read returns the staged value on `reg_rdata` in the cycle after `reg_re`, with every other bit read as 0.
- R3: Writing a route register does not change the routing until a commit is made.
- R4: A write to address 0x00 with bit 1 set commits all staged routes. Address 0x00 always reads back 0, and the commit request lasts a single cycle.
- R5: An enabled output with no sharers carries its source's `s_valid`, data and `s_last`, and that source's `s_ready` equals the output's `m_ready`.
- R6: An output that is off never asserts `m_valid`. An input that no enabled output selects keeps `s_ready` low.
- R7: A source number equal to or above the number of inputs makes the output behave exactly as if it were off.
- R8: When several enabled outputs select one input, that input's `s_ready` is the AND of their `m_ready`. Each of those outputs asserts `m_valid` only when the input is valid and all the other sharing outputs are ready.
- R9: A committed route change on an output waits while that output is inside a packet. It takes effect in the cycle after the beat carrying `s_last` is accepted.
- R10: Switching every output off and committing stops all traffic: `m_valid` and `s_ready` are low on every port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_raddr | input | ADDR_W | Register read byte address |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| s_valid | input | N_IN | Input stream valid, one bit per input |
| s_ready | output | N_IN | Input stream ready, one bit per input |
| s_data | input | N_IN*DATA_W | Input stream data, input i at bits [i*DATA_W +: DATA_W] |
| s_last | input | N_IN | Input end-of-packet flag |
| m_valid | output | N_OUT | Output stream valid, one bit per output |
| m_ready | input | N_OUT | Output stream ready |
| m_data | output | N_OUT*DATA_W | Output stream data, output j at bits [j*DATA_W +: DATA_W] |
| m_last | output | N_OUT | Output end-of-packet flag |

## Verification
Several routing tables are tried in turn: a straight one-to-one mapping, and a reversed mapping with a mix of valid and ready bits that tells whether each output really picks its own source. A full fan-out from one input is tried with all outputs ready and then with one output stalled, to separate the AND of the readies from a simple copy. A table with an out-of-range source next to an off bit shows that both behave the same. A packet that is held open across a commit shows whether the switch waits for the beat carrying `s_last`, and a staged-but-uncommitted write shows whether the routing leaks through early.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int SEL_W      = 4;
  localparam int REG_W      = 32;
  localparam int OFF_BIT    = 31;
  localparam int COMMIT_BIT = 1;
  localparam int MUX_BASE   = 64;

  typedef struct packed {
    logic             off;
    logic [SEL_W-1:0] src;
  } route_t;

  localparam route_t ROUTE_OFF = '{off: 1'b1, src: '0};
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xbar_regs.sv
module xbar_regs
  import xbar_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [REG_W-1:0]         wdata,
  input  logic                     re,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [REG_W-1:0]         rdata,
  output logic                     commit,
  output route_t [N_OUT-1:0]       staged
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(MUX_BASE);
  localparam logic [IDX_W-1:0]  NOUT_I = IDX_W'(N_OUT);

  route_t [N_OUT-1:0] staged_q;
  route_t [N_OUT-1:0] staged_d;
  logic               commit_q;
  logic               commit_d;
  logic [REG_W-1:0]   rdata_q;
  logic [REG_W-1:0]   rdata_d;
  logic [ADDR_W-1:0]  woff;
  logic [IDX_W-1:0]   widx;
  logic               mux_hit;
  logic               unused_wdata;

  assign unused_wdata = ^wdata;

  // write decode
  always_comb begin
    woff     = waddr - BASE_A;
    widx     = woff[ADDR_W-1:2];
    commit_d = we && (waddr == '0) && wdata[COMMIT_BIT];
    mux_hit  = we && (waddr >= BASE_A) && (woff[1:0] == 2'b00) && (widx < NOUT_I);
  end

  // staged route next state
  always_comb begin
    staged_d = staged_q;
    for (int j = 0; j < N_OUT; j++) begin
      if (mux_hit && (widx == IDX_W'(j))) begin
        staged_d[j].off = wdata[OFF_BIT];
        staged_d[j].src = wdata[SEL_W-1:0];
      end
    end
  end

  // read mux: the control address never matches a route slot, so it reads 0
  always_comb begin
    rdata_d = '0;
    for (int j = 0; j < N_OUT; j++) begin
      if (raddr == (BASE_A + ADDR_W'(4 * j))) begin
        rdata_d[OFF_BIT]     = staged_q[j].off;
        rdata_d[SEL_W-1:0]   = staged_q[j].src;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      rdata_q  <= '0;
      for (int j = 0; j < N_OUT; j++) begin
        staged_q[j] <= ROUTE_OFF;
      end
    end else begin
      commit_q <= commit_d;
      if (mux_hit) begin
        staged_q <= staged_d;
      end
      if (re) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign rdata  = rdata_q;
  assign commit = commit_q;
  assign staged = staged_q;

  // R4
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re && (raddr == '0)) |=> (rdata == '0));

  // R2
  reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> (rdata[OFF_BIT-1:SEL_W] == '0));
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port
  import xbar_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   commit_i,
  input  route_t staged_i,
  input  logic   valid_i,
  input  logic   ready_i,
  input  logic   last_i,
  output route_t act_o
);
  route_t act_q;
  route_t act_d;
  route_t pend_route_q;
  logic   pend_q;
  logic   pend_d;
  logic   in_pkt_q;
  logic   in_pkt_d;
  logic   fire;
  logic   apply;

  always_comb begin
    fire     = valid_i && ready_i;
    in_pkt_d = fire ? !last_i : in_pkt_q;
    apply    = pend_q && !in_pkt_d;
    pend_d   = pend_q;
    if (commit_i) begin
      pend_d = 1'b1;
    end else if (apply) begin
      pend_d = 1'b0;
    end
    act_d = apply ? pend_route_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q        <= ROUTE_OFF;
      pend_route_q <= ROUTE_OFF;
      pend_q       <= 1'b0;
      in_pkt_q     <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      in_pkt_q <= in_pkt_d;
      if (commit_i) begin
        pend_route_q <= staged_i;
      end
      if (apply) begin
        act_q <= act_d;
      end
    end
  end

  assign act_o = act_q;

  // R9
  mid_pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && !(fire && last_i)) |=> $stable(act_q));

  // R3
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i && !pend_q) |=> $stable(act_q));
endmodule

// File: rtl/stream_xbar.sv
module stream_xbar
  import xbar_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_waddr,
  input  logic [31:0]               reg_wdata,
  input  logic                      reg_re,
  input  logic [ADDR_W-1:0]         reg_raddr,
  output logic [31:0]               reg_rdata,
  input  logic [N_IN-1:0]           s_valid,
  output logic [N_IN-1:0]           s_ready,
  input  logic [N_IN*DATA_W-1:0]    s_data,
  input  logic [N_IN-1:0]           s_last,
  output logic [N_OUT-1:0]          m_valid,
  input  logic [N_OUT-1:0]          m_ready,
  output logic [N_OUT*DATA_W-1:0]   m_data,
  output logic [N_OUT-1:0]          m_last
);
  localparam int SW1 = SEL_W + 1;
  localparam logic [SW1-1:0] NIN_V = SW1'(N_IN);

  logic               rst_sync_n;
  logic               commit;
  route_t [N_OUT-1:0] staged;
  route_t [N_OUT-1:0] act;
  logic [N_OUT-1:0]   en;

  xbar_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xbar_regs #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) i_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (reg_we),
    .waddr  (reg_waddr),
    .wdata  (reg_wdata),
    .re     (reg_re),
    .raddr  (reg_raddr),
    .rdata  (reg_rdata),
    .commit (commit),
    .staged (staged)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    xbar_out_port i_port (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .commit_i (commit),
      .staged_i (staged[j]),
      .valid_i  (m_valid[j]),
      .ready_i  (m_ready[j]),
      .last_i   (m_last[j]),
      .act_o    (act[j])
    );
  end

  // an out-of-range source counts as off
  always_comb begin
    for (int j = 0; j < N_OUT; j++) begin
      en[j] = !act[j].off && ({1'b0, act[j].src} < NIN_V);
    end
  end

  // forward path: data, last, valid qualified by sharers' readiness
  always_comb begin
    logic sv;
    logic ok;
    m_valid = '0;
    m_data  = '0;
    m_last  = '0;
    for (int j = 0; j < N_OUT; j++) begin
      sv = 1'b0;
      ok = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (en[j] && (act[j].src == SEL_W'(i))) begin
          sv                          = s_valid[i];
          m_data[j*DATA_W +: DATA_W]  = s_data[i*DATA_W +: DATA_W];
          m_last[j]                   = s_last[i];
        end
      end
      for (int k = 0; k < N_OUT; k++) begin
        if ((k != j) && en[k] && (act[k].src == act[j].src)) begin
          ok = ok & m_ready[k];
        end
      end
      m_valid[j] = en[j] & sv & ok;
    end
  end

  // backward path: AND of readies over every output selecting the input
  always_comb begin
    logic any;
    logic all;
    s_ready = '0;
    for (int i = 0; i < N_IN; i++) begin
      any = 1'b0;
      all = 1'b1;
      for (int j = 0; j < N_OUT; j++) begin
        if (en[j] && (act[j].src == SEL_W'(i))) begin
          any = 1'b1;
          all = all & m_ready[j];
        end
      end
      s_ready[i] = any & all;
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_chk_o
    for (genvar i = 0; i < N_IN; i++) begin : g_chk_i
      // R5
      src_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (en[j] && (act[j].src == SEL_W'(i)) && m_valid[j]) |-> s_valid[i]);

      // R8
      xfer_join_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (en[j] && (act[j].src == SEL_W'(i)) && m_valid[j] && m_ready[j]) |-> s_ready[i]);
    end
  end
endmodule

// File: tb/test_stream_xbar.sv
module test_stream_xbar;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int DW = 16;
  localparam int AW = 8;

  typedef logic [27:0] vec_t;
  // {route o3, o2, o1, o0 (each {off, src[3:0]}), s_valid[3:0], m_ready[3:0]}
  localparam vec_t VECS [6] = '{
    {5'h03, 5'h02, 5'h01, 5'h00, 4'b1111, 4'b1111},
    {5'h00, 5'h01, 5'h02, 5'h03, 4'b1010, 4'b0110},
    {5'h02, 5'h02, 5'h02, 5'h02, 4'b0100, 4'b1111},
    {5'h02, 5'h02, 5'h02, 5'h02, 4'b0100, 4'b1011},
    {5'h00, 5'h01, 5'h11, 5'h09, 4'b1111, 4'b1111},
    {5'h10, 5'h10, 5'h10, 5'h10, 4'b1111, 4'b1111}
  };

  logic            clk;
  logic            rst_n;
  logic            reg_we;
  logic [AW-1:0]   reg_waddr;
  logic [31:0]     reg_wdata;
  logic            reg_re;
  logic [AW-1:0]   reg_raddr;
  logic [31:0]     reg_rdata;
  logic [NI-1:0]   s_valid;
  logic [NI-1:0]   s_ready;
  logic [NI*DW-1:0] s_data;
  logic [NI-1:0]   s_last;
  logic [NO-1:0]   m_valid;
  logic [NO-1:0]   m_ready;
  logic [NO*DW-1:0] m_data;
  logic [NO-1:0]   m_last;

  int n_checks = 0;
  int n_errors = 0;

  stream_xbar #(.N_IN(NI), .N_OUT(NO), .DATA_W(DW), .ADDR_W(AW)) i_stream_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_re    (reg_re),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .s_last    (s_last),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_last    (m_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] dval(input int i);
    return DW'(16'h1100 * (i + 1));
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_raddr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic commit_settle();
    wr('0, 32'h0000_0002);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_waddr = '0; reg_raddr = '0; reg_wdata = '0;
    s_valid = '1; s_last = '1; m_ready = '1;
    for (int i = 0; i < NI; i++) s_data[i*DW +: DW] = dval(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check(32'(m_valid), 32'h0, "R1", "m_valid after reset");
    check(32'(s_ready), 32'h0, "R1", "s_ready after reset");
    rd(8'h40, rv); check(rv, 32'h8000_0000, "R1", "route0 reset value");
    rd(8'h4C, rv); check(rv, 32'h8000_0000, "R1", "route3 reset value");
    // R2 register layout and readback
    wr(8'h44, 32'hFFFF_FFF2);
    rd(8'h44, rv); check(rv, 32'h8000_0002, "R2", "route1 readback");
    wr(8'h48, 32'h0000_0003);
    rd(8'h48, rv); check(rv, 32'h0000_0003, "R2", "route2 readback");
    wr(8'h44, 32'h8000_0000);
    wr(8'h48, 32'h8000_0000);
    // R3 staging without commit
    wr(8'h40, 32'h0000_0001);
    repeat (4) @(negedge clk);
    #1;
    check(32'(m_valid), 32'h0, "R3", "m_valid before commit");
    // R4 commit
    commit_settle();
    #1;
    check(32'(m_valid), 32'h1, "R4", "m_valid after commit");
    check(32'(m_data[DW-1:0]), 32'(dval(1)), "R4", "m_data0 after commit");
    check(32'(s_ready), 32'h2, "R5", "s_ready single route");
    rd(8'h00, rv); check(rv, 32'h0, "R4", "control readback");

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [19:0] cfg;
      logic [NI-1:0] sv;
      logic [NO-1:0] mr;
      logic [NO-1:0] en;
      logic [3:0] src [NO];
      logic [NO-1:0] exp_mv;
      logic [NI-1:0] exp_sr;
      string req;
      cfg = VECS[v][27:8];
      sv  = VECS[v][7:4];
      mr  = VECS[v][3:0];
      req = (v < 2) ? "R5" : (v < 4) ? "R8" : (v == 4) ? "R7" : "R10";
      @(negedge clk);
      s_valid = '0; m_ready = '0; s_last = '1;
      for (int j = 0; j < NO; j++) begin
        wr(AW'(8'h40 + 4 * j), {cfg[j*5+4], 27'b0, cfg[j*5 +: 4]});
        src[j] = cfg[j*5 +: 4];
        en[j]  = !cfg[j*5+4] && (src[j] < 4'(NI));
      end
      commit_settle();
      s_valid = sv; m_ready = mr;
      #1;
      for (int j = 0; j < NO; j++) begin
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < NO; k++)
          if (k != j && en[k] && src[k] == src[j]) ok = ok & mr[k];
        exp_mv[j] = en[j] && sv[src[j][1:0]] && ok;
      end
      for (int i = 0; i < NI; i++) begin
        logic any;
        logic all;
        any = 1'b0; all = 1'b1;
        for (int j = 0; j < NO; j++)
          if (en[j] && src[j] == 4'(i)) begin any = 1'b1; all = all & mr[j]; end
        exp_sr[i] = any & all;
      end
      check(32'(m_valid), 32'(exp_mv), req, $sformatf("m_valid vector %0d", v));
      check(32'(s_ready), 32'(exp_sr), (v == 5) ? "R10" : "R6", $sformatf("s_ready vector %0d", v));
      for (int j = 0; j < NO; j++) begin
        if (en[j]) begin
          check(32'(m_data[j*DW +: DW]), 32'(dval(int'(src[j]))), req, $sformatf("m_data%0d vector %0d", j, v));
          check(32'(m_last[j]), 32'h1, req, $sformatf("m_last%0d vector %0d", j, v));
        end
      end
    end

    // R9 packet boundary
    @(negedge clk);
    s_valid = '0; m_ready = '0; s_last = '1;
    wr(8'h40, 32'h0000_0000);
    commit_settle();
    s_valid[0] = 1'b1; s_last[0] = 1'b0; m_ready[0] = 1'b1;
    @(negedge clk);
    m_ready[0] = 1'b0; s_valid[1] = 1'b1;
    wr(8'h40, 32'h0000_0001);
    wr(8'h00, 32'h0000_0002);
    repeat (6) @(negedge clk);
    #1;
    check(32'(m_data[DW-1:0]), 32'(dval(0)), "R9", "route held mid-packet");
    check(32'(m_valid[0]), 32'h1, "R9", "valid held mid-packet");
    @(negedge clk);
    s_last[0] = 1'b1; m_ready[0] = 1'b1;
    @(negedge clk);
    #1;
    check(32'(m_data[DW-1:0]), 32'(dval(1)), "R9", "route switched after last");
    check(32'(s_ready), 32'h2, "R9", "s_ready after switch");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule